// File: doc/BRIEF.md
# Character LCD 4-Bit Interface Controller

This block connects a byte-oriented client to a character LCD module that is wired with only four data lines. It generates the enable strobe, the read/write line and the register-select line that tells the module whether a byte is a command or display data. Every byte goes out as two nibbles, most significant nibble first.

After reset the controller runs the module's wake-up sequence without any help from the client. It waits for the supply to settle and sends three timed 0x3 nibbles. It then polls the busy flag and sends nibble 0x2 to switch the module into 4-bit mode. Last, it issues a fixed list of six setup commands.

Before every byte, the controller reads the status register as two nibbles and repeats the read while the busy flag is set. During a read the data lines are released. Once `init_done` is high, the client hands over bytes through a valid/ready stream. The client raises `in_valid` with `in_data` and `in_is_data`, and must hold all three until it sees `in_ready` high at a clock edge. That edge is the transfer. `in_ready` then stays low until the byte's second nibble has been strobed into the module. Inputs that change while `in_ready` is low are not looked at.

Top module: `lcd_nibble_ctrl`

## Requirements
- R1: After reset release, `lcd_en` stays low for at least PWR_WAIT_US microseconds. `init_done` and `in_ready` are low from reset until initialization completes.
- R2: The first three enable strobes are writes of nibble 0x3 with `lcd_rs` low. At least GAP_A_US microseconds separate the rising edges of strobes one and two, and at least GAP_B_US separate strobes two and three. A busy poll follows, then a write of nibble 0x2.
- R3: Six command bytes follow, in this order: 0x20, 0x08, 0x01, 0x06, 0x0C, 0x01. Each is preceded by a busy poll.
- R4: Each byte is written as two strobes: bits 7..4 first, then bits 3..0. `lcd_rs` is 1 for display data (`in_is_data`=1) and 0 for commands.
- R5: A busy poll consists of two strobes with `lcd_rw`=1, `lcd_rs`=0 and `lcd_db_oe`=0. The busy flag is bit 3 of the nibble read in the first strobe, which is bit 7 of the status byte. The poll repeats while that bit is 1.
- R6: Outside read strobes, `lcd_rw` is 0 and `lcd_db_oe` is 1, so the data lines are driven. `lcd_rw` is never 1 while `lcd_db_oe` is 1.
- R7: `lcd_en` stays high for at least ceil(450 ns × CLK_HZ) clocks. `lcd_db_o`, `lcd_rs`, `lcd_rw` and `lcd_db_oe` do not change while `lcd_en` is high.
- R8: `in_ready` is high only when `init_done` is high and the controller is idle. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until that byte's second nibble has been strobed. `in_data` and `in_is_data` are ignored while `in_ready` is low.
- R9: `init_done` rises after the second nibble of the last setup command and then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Byte to send to the module |
| in_is_data | input | 1 | 1 = display data, 0 = command |
| in_valid | input | 1 | Client offers a byte |
| in_ready | output | 1 | Controller accepts a byte this cycle |
| init_done | output | 1 | Wake-up sequence and setup commands finished |
| lcd_db_o | output | 4 | Nibble driven onto the module data lines |
| lcd_db_i | input | 4 | Nibble read back from the module data lines |
| lcd_db_oe | output | 1 | 1 = drive the data lines, 0 = release them |
| lcd_en | output | 1 | Enable strobe; the module latches on its falling edge |
| lcd_rw | output | 1 | 1 = read status, 0 = write |
| lcd_rs | output | 1 | Register select: 1 = data, 0 = command |

## Verification
A modelled LCD logs every enable strobe with its direction, its register select and its nibble. It answers status reads from a programmable count of busy responses.

The wake-up run is checked for timing, for nibble order and for the six setup commands, with one busy response on the first poll. A data byte with no busy responses shows the high-nibble-first order and `lcd_rs` high. A command byte with three busy responses separates a correct poll loop from one that gives up after the first poll or ignores bit 3. Two back-to-back data bytes, with `in_data` corrupted while `in_ready` is low, show that only the handshake edge captures the byte.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [2:0] {
    S_WAIT, S_NIB, S_PHI, S_PLO, S_BHI, S_BLO, S_IDLE
  } seq_state_t;

  typedef enum logic [1:0] {
    G_BOOT, G_MODE, G_CMD, G_RUN
  } stage_t;

  typedef enum logic [1:0] {
    P_IDLE, P_SETUP, P_HIGH, P_LOW
  } phy_state_t;

  localparam int NUM_SETUP_CMDS = 6;

  function automatic logic [7:0] setup_cmd(input logic [2:0] idx);
    case (idx)
      3'd0:    setup_cmd = 8'h20;
      3'd1:    setup_cmd = 8'h08;
      3'd2:    setup_cmd = 8'h01;
      3'd3:    setup_cmd = 8'h06;
      3'd4:    setup_cmd = 8'h0C;
      default: setup_cmd = 8'h01;
    endcase
  endfunction

endpackage

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
  parameter int W         = 24,
  parameter int RST_TICKS = 1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ticks,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= W'(RST_TICKS);
    else if (load)       cnt <= ticks;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0) && !load;

endmodule

// File: rtl/lcd_nibble_phy.sv
module lcd_nibble_phy
  import lcd_pkg::*;
#(
  parameter int SETUP_CYC = 6,
  parameter int HIGH_CYC  = 45
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       req_wr,
  input  logic       req_rs,
  input  logic [3:0] req_nib,
  output logic       done,
  output logic [3:0] rd_nib,
  output logic [3:0] lcd_db_o,
  input  logic [3:0] lcd_db_i,
  output logic       lcd_db_oe,
  output logic       lcd_en,
  output logic       lcd_rw,
  output logic       lcd_rs
);
  localparam int CMAX = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  phy_state_t    ph;
  logic [CW-1:0] cnt;
  logic          wr_q, rs_q;
  logic [3:0]    nib_q;
  logic          reading;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= P_IDLE;
      cnt    <= '0;
      wr_q   <= 1'b1;
      rs_q   <= 1'b0;
      nib_q  <= '0;
      rd_nib <= '0;
    end else begin
      case (ph)
        P_IDLE: if (req) begin
          wr_q  <= req_wr;
          rs_q  <= req_rs;
          nib_q <= req_nib;
          cnt   <= CW'(SETUP_CYC - 1);
          ph    <= P_SETUP;
        end
        P_SETUP: if (cnt == '0) begin
          cnt <= CW'(HIGH_CYC - 1);
          ph  <= P_HIGH;
        end else cnt <= cnt - 1'b1;
        P_HIGH: if (cnt == '0) begin
          rd_nib <= lcd_db_i;
          cnt    <= CW'(HIGH_CYC - 1);
          ph     <= P_LOW;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) ph <= P_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign reading   = (ph != P_IDLE) && !wr_q;
  assign done      = (ph == P_LOW) && (cnt == '0);
  assign lcd_en    = (ph == P_HIGH);
  assign lcd_rw    = reading;
  assign lcd_db_oe = !reading;
  assign lcd_rs    = (ph != P_IDLE) && rs_q;
  assign lcd_db_o  = nib_q;

  // strobe width observer for the checks below
  logic [CW:0] hi_len;
  always_ff @(posedge clk) begin
    if (!rst_n)      hi_len <= '0;
    else if (lcd_en) hi_len <= hi_len + 1'b1;
    else             hi_len <= '0;
  end

  p_en_min_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_en) |-> (hi_len >= (CW+1)'(HIGH_CYC)));

  p_bus_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && $past(lcd_en)) |-> ($stable(lcd_db_o) && $stable(lcd_rs) &&
                                   $stable(lcd_rw) && $stable(lcd_db_oe)));

endmodule

// File: rtl/lcd_nibble_ctrl.sv
module lcd_nibble_ctrl
  import lcd_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int PWR_WAIT_US = 20_000,
  parameter int GAP_A_US    = 5_000,
  parameter int GAP_B_US    = 1_000,
  parameter int EN_HIGH_NS  = 450,
  parameter int SETUP_NS    = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_is_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       init_done,
  output logic [3:0] lcd_db_o,
  input  logic [3:0] lcd_db_i,
  output logic       lcd_db_oe,
  output logic       lcd_en,
  output logic       lcd_rw,
  output logic       lcd_rs
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int T_PWR  = CYC_PER_US * PWR_WAIT_US;
  localparam int T_GAPA = CYC_PER_US * GAP_A_US;
  localparam int T_GAPB = CYC_PER_US * GAP_B_US;
  localparam int T_M1   = (T_PWR > T_GAPA) ? T_PWR : T_GAPA;
  localparam int T_MAX  = (T_M1 > T_GAPB) ? T_M1 : T_GAPB;
  localparam int TW     = $clog2(T_MAX + 1);
  localparam int HIGH_RAW  = ((CLK_HZ / 1000) * EN_HIGH_NS + 999_999) / 1_000_000;
  localparam int SETUP_RAW = ((CLK_HZ / 1000) * SETUP_NS + 999_999) / 1_000_000;
  localparam int HIGH_CYC  = (HIGH_RAW < 1) ? 1 : HIGH_RAW;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam logic [2:0] LAST_CMD = 3'(NUM_SETUP_CMDS - 1);

  seq_state_t state;
  stage_t     stage;
  logic [1:0] boot_k;
  logic [2:0] cmd_idx;
  logic       busy_q, rs_q;
  logic [7:0] byte_q;

  logic          t_load, t_done;
  logic [TW-1:0] t_ticks;
  logic          phy_req, phy_wr, phy_rs, phy_done;
  logic [3:0]    phy_nib, phy_rd;

  lcd_wait_timer #(.W(TW), .RST_TICKS(T_PWR)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .ticks(t_ticks), .expired(t_done)
  );

  lcd_nibble_phy #(.SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC)) u_phy (
    .clk(clk), .rst_n(rst_n), .req(phy_req), .req_wr(phy_wr), .req_rs(phy_rs),
    .req_nib(phy_nib), .done(phy_done), .rd_nib(phy_rd),
    .lcd_db_o(lcd_db_o), .lcd_db_i(lcd_db_i), .lcd_db_oe(lcd_db_oe),
    .lcd_en(lcd_en), .lcd_rw(lcd_rw), .lcd_rs(lcd_rs)
  );

  assign t_load  = (state == S_NIB) && phy_done && (stage == G_BOOT) && (boot_k != 2'd2);
  assign t_ticks = (boot_k == 2'd0) ? TW'(T_GAPA) : TW'(T_GAPB);

  always_comb begin
    phy_req = 1'b1;
    phy_wr  = 1'b1;
    phy_rs  = 1'b0;
    phy_nib = 4'h0;
    case (state)
      S_NIB:        phy_nib = (stage == G_MODE) ? 4'h2 : 4'h3;
      S_PHI, S_PLO: phy_wr  = 1'b0;
      S_BHI: begin phy_nib = byte_q[7:4]; phy_rs = rs_q; end
      S_BLO: begin phy_nib = byte_q[3:0]; phy_rs = rs_q; end
      default:      phy_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_WAIT;
      stage   <= G_BOOT;
      boot_k  <= '0;
      cmd_idx <= '0;
      busy_q  <= 1'b0;
      rs_q    <= 1'b0;
      byte_q  <= '0;
    end else begin
      case (state)
        S_WAIT: if (t_done) state <= S_NIB;
        S_NIB: if (phy_done) begin
          if (stage == G_BOOT) begin
            if (boot_k == 2'd2) begin
              stage <= G_MODE;
              state <= S_PHI;
            end else begin
              boot_k <= boot_k + 1'b1;
              state  <= S_WAIT;
            end
          end else begin
            stage   <= G_CMD;
            cmd_idx <= '0;
            state   <= S_PHI;
          end
        end
        S_PHI: if (phy_done) begin
          busy_q <= phy_rd[3];
          state  <= S_PLO;
        end
        S_PLO: if (phy_done) begin
          if (busy_q)              state <= S_PHI;
          else if (stage == G_MODE) state <= S_NIB;
          else begin
            if (stage == G_CMD) begin
              byte_q <= setup_cmd(cmd_idx);
              rs_q   <= 1'b0;
            end
            state <= S_BHI;
          end
        end
        S_BHI: if (phy_done) state <= S_BLO;
        S_BLO: if (phy_done) begin
          if (stage == G_CMD && cmd_idx != LAST_CMD) begin
            cmd_idx <= cmd_idx + 1'b1;
            state   <= S_PHI;
          end else begin
            stage <= G_RUN;
            state <= S_IDLE;
          end
        end
        default: if (in_valid) begin
          byte_q <= in_data;
          rs_q   <= in_is_data;
          state  <= S_PHI;
        end
      endcase
    end
  end

  assign init_done = (stage == G_RUN);
  assign in_ready  = (state == S_IDLE);

  p_quiet_in_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> !lcd_en);

  p_low_after_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BLO) |-> ($past(state) == S_BHI || $past(state) == S_BLO));

  p_read_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_PHI || state == S_PLO) && lcd_en) |-> (lcd_rw && !lcd_rs && !lcd_db_oe));

  p_write_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_NIB || state == S_BHI || state == S_BLO) && lcd_en) |-> (!lcd_rw && lcd_db_oe));

  p_ready_needs_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> init_done);

  p_accept_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_init_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

endmodule

// File: tb/lcd_nibble_ctrl_test.sv
`timescale 1ns/1ps
module lcd_nibble_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_is_data = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready, init_done;
  logic [3:0] lcd_db_o, lcd_db_i;
  logic       lcd_db_oe, lcd_en, lcd_rw, lcd_rs;

  always #5 clk = ~clk;

  lcd_nibble_ctrl #(
    .CLK_HZ(100_000_000), .PWR_WAIT_US(20), .GAP_A_US(5), .GAP_B_US(1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_is_data(in_is_data),
    .in_valid(in_valid), .in_ready(in_ready), .init_done(init_done),
    .lcd_db_o(lcd_db_o), .lcd_db_i(lcd_db_i), .lcd_db_oe(lcd_db_oe),
    .lcd_en(lcd_en), .lcd_rw(lcd_rw), .lcd_rs(lcd_rs)
  );

  int vectors = 0;
  int miscompares = 0;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // LCD model: strobe log and busy flag
  logic       ev_rw  [0:255];
  logic       ev_rs  [0:255];
  logic [3:0] ev_nib [0:255];
  longint     ev_t   [0:255];
  int         ev_n = 0;
  longint     t_rise = 0;
  longint     t_rel = 0;
  longint     min_high = 64'd1000000;
  int         busy_left = 0;
  bit         rd_phase = 1'b0;
  int         dir_bad = 0;

  assign lcd_db_i = rd_phase ? 4'b0110 : {(busy_left != 0), 3'b010};

  always @(posedge lcd_en) t_rise = $time;

  always @(negedge lcd_en) begin
    if (ev_n < 256) begin
      ev_rw[ev_n]  = lcd_rw;
      ev_rs[ev_n]  = lcd_rs;
      ev_nib[ev_n] = lcd_rw ? 4'h0 : lcd_db_o;
      ev_t[ev_n]   = t_rise;
    end
    ev_n++;
    if ($time - t_rise < min_high) min_high = $time - t_rise;
    if (lcd_rw) begin
      if (!rd_phase) rd_phase = 1'b1;
      else begin
        rd_phase = 1'b0;
        if (busy_left > 0) busy_left--;
      end
    end
  end

  always @(posedge clk) if (rst_n && lcd_rw && lcd_db_oe) dir_bad++;

  task automatic expect_ev(input int idx, input bit rw, input bit rs, input logic [3:0] nib,
                           input string req);
    check_eq(req, $sformatf("strobe %0d rw", idx), int'(ev_rw[idx]), int'(rw));
    check_eq(req, $sformatf("strobe %0d rs", idx), int'(ev_rs[idx]), int'(rs));
    if (!rw) check_eq(req, $sformatf("strobe %0d nibble", idx), int'(ev_nib[idx]), int'(nib));
  endtask

  task automatic send(input logic [7:0] b, input bit is_data);
    @(negedge clk);
    in_data = b; in_is_data = is_data; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data = 8'hFF;       // garbage while not ready
    in_is_data = ~is_data;
    check_eq("R8", "ready after accept", int'(in_ready), 0);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!in_ready && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check_eq("R1", "en in reset", int'(lcd_en), 0);
    check_eq("R9", "init_done in reset", int'(init_done), 0);
    check_eq("R8", "ready in reset", int'(in_ready), 0);
    check_eq("R6", "rw in reset", int'(lcd_rw), 0);
    check_eq("R6", "oe in reset", int'(lcd_db_oe), 1);
    rst_n = 1'b1;
    t_rel = $time;
  endtask

  task automatic t_boot();
    int n = 0;
    busy_left = 1;
    while (!init_done && n < 30000) begin
      @(negedge clk); n++;
      if (in_ready && !init_done) check_eq("R8", "ready before init", 1, 0);
    end
    check_eq("R9", "init_done", int'(init_done), 1);
    check_eq("R8", "ready after init", int'(in_ready), 1);
    check_eq("R3", "boot strobe count", ev_n, 32);
    check_eq("R1", "power wait", int'((ev_t[0] - t_rel) >= 20000), 1);
    check_eq("R2", "gap A", int'((ev_t[1] - ev_t[0]) >= 5000), 1);
    check_eq("R2", "gap B", int'((ev_t[2] - ev_t[1]) >= 1000), 1);
    for (int i = 0; i < 3; i++) expect_ev(i, 1'b0, 1'b0, 4'h3, "R2");
    for (int i = 3; i < 7; i++) expect_ev(i, 1'b1, 1'b0, 4'h0, "R5");
    expect_ev(7, 1'b0, 1'b0, 4'h2, "R2");
    begin
      logic [7:0] cmds [0:5] = '{8'h20, 8'h08, 8'h01, 8'h06, 8'h0C, 8'h01};
      for (int k = 0; k < 6; k++) begin
        expect_ev(8 + 4*k, 1'b1, 1'b0, 4'h0, "R3");
        expect_ev(9 + 4*k, 1'b1, 1'b0, 4'h0, "R3");
        expect_ev(10 + 4*k, 1'b0, 1'b0, cmds[k][7:4], "R3");
        expect_ev(11 + 4*k, 1'b0, 1'b0, cmds[k][3:0], "R3");
      end
    end
    repeat (20) @(negedge clk);
    check_eq("R9", "init_done stays", int'(init_done), 1);
  endtask

  task automatic t_data_byte();
    int base = ev_n;
    busy_left = 0;
    send(8'hA5, 1'b1);
    wait_idle();
    check_eq("R4", "data strobe count", ev_n - base, 4);
    expect_ev(base,     1'b1, 1'b0, 4'h0, "R5");
    expect_ev(base + 1, 1'b1, 1'b0, 4'h0, "R5");
    expect_ev(base + 2, 1'b0, 1'b1, 4'hA, "R4");
    expect_ev(base + 3, 1'b0, 1'b1, 4'h5, "R4");
  endtask

  task automatic t_busy_cmd();
    int base = ev_n;
    busy_left = 3;
    send(8'h80, 1'b0);
    wait_idle();
    check_eq("R5", "busy strobe count", ev_n - base, 10);
    for (int i = 0; i < 8; i++) expect_ev(base + i, 1'b1, 1'b0, 4'h0, "R5");
    expect_ev(base + 8, 1'b0, 1'b0, 4'h8, "R4");
    expect_ev(base + 9, 1'b0, 1'b0, 4'h0, "R4");
  endtask

  task automatic t_back_to_back();
    int base = ev_n;
    busy_left = 0;
    send(8'h3C, 1'b1);
    send(8'hC7, 1'b1);
    wait_idle();
    check_eq("R8", "pair strobe count", ev_n - base, 8);
    expect_ev(base + 2, 1'b0, 1'b1, 4'h3, "R8");
    expect_ev(base + 3, 1'b0, 1'b1, 4'hC, "R8");
    expect_ev(base + 6, 1'b0, 1'b1, 4'hC, "R8");
    expect_ev(base + 7, 1'b0, 1'b1, 4'h7, "R8");
  endtask

  task automatic t_timing();
    check_eq("R7", "min enable high >= 450ns", int'(min_high >= 450), 1);
    check_eq("R6", "rw with driven bus", dir_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_boot();
    t_data_byte();
    t_busy_cmd();
    t_back_to_back();
    t_timing();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule